// File: doc/BRIEF.md
# Byte Program Sequencer with Pulse-and-Verify Retry

This block runs on the host side of a byte-programmable flash device and drives it through a simple bus-cycle handshake. A request names a first address, a byte value and a span, which is the number of bytes minus one. For every address in the span the block does the following:

- It raises the high-voltage enable.
- It sends the program set-up command, then a write that carries the target address and byte.
- It waits out the programming pulse.
- It sends the program-verify command, waits the margin settling time, and reads the byte back.

A read-back that differs from the requested byte in any bit triggers another pulse. A byte gets at most a fixed number of pulses. When the range finishes, or when a byte runs out of pulses, the block writes the read-mode command, drops the high-voltage enable and reports done together with a pass flag.

Each bus cycle is presented as a request held steady until the device side acknowledges it. Both waits are counted in clock cycles, so the real-time values come from the parameters at the chosen clock rate.

Top module: `byte_prog_seq`

## Requirements
- R1: After reset `busy`, `done`, `pass`, `hv_en` and `bus_req` are all 0.
- R2: A `start` seen while idle latches the request, raises `hv_en` and opens with a write of 40h. A `start` seen while busy has no effect on the bus traffic or on the device contents.
- R3: The write that follows each 40h carries the current target address on `bus_addr` and the requested byte on `bus_wdata`.
- R4: After that address/data write is acknowledged, at least `PULSE_CYC` cycles pass before the next request, which is a write of C0h.
- R5: After the C0h write is acknowledged, at least `VERIFY_CYC` cycles pass before a read cycle (`bus_we` = 0).
- R6: A read-back that differs from the requested byte in any bit starts a new 40h and address/data pair for the same address, as long as fewer than `MAX_PULSES` (default 25) pulses have been given to that byte.
- R7: When the verify that follows pulse number `MAX_PULSES` fails, the run ends. The block writes 00h, clears `hv_en`, pulses `done` with `pass` = 0, and gives no pulse to any later address.
- R8: A matching read-back clears the pulse count and moves to the next address. A byte that matches right after its `MAX_PULSES`-th pulse counts as programmed.
- R9: After the last address verifies, the block writes 00h, then clears `hv_en` and pulses `done` for one cycle with `pass` = 1. `pass` holds its value until the next start. `hv_en` is high whenever a bus cycle is requested.
- R10: `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay constant from the cycle a request is raised until the cycle it is acknowledged.
- R11: A span of 0 programs exactly one byte, and a span of N programs the N+1 consecutive addresses starting at `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run (ignored while busy) |
| req_addr | input | AW | First address of the range |
| req_data | input | 8 | Byte value programmed at every address |
| req_span | input | AW | Number of bytes minus one |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Result of the last run, 1 = every byte verified |
| hv_en | output | 1 | High-voltage enable for the device |
| bus_req | output | 1 | Bus cycle requested |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Bus cycle address |
| bus_wdata | output | 8 | Write data or command byte |
| bus_ack | input | 1 | Device side completes the current cycle |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` on a read |

## Verification
The critical coincidence is a byte whose verify succeeds right after pulse `MAX_PULSES`. In that same read-acknowledge cycle, the pulse-limit decision and the match-and-advance decision are both armed.

The device model is told that one byte needs exactly 25 pulses before it takes the value. The run is judged correct only if it ends with `pass` = 1, exactly 25 pulses were counted at that address, and the following byte was programmed. A second case needs 26 pulses and must end with `pass` = 0 after exactly 25.

// File: rtl/bps_pkg.sv
package bps_pkg;

    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_SETUP  = 8'h40;
    localparam logic [7:0] CMD_VERIFY = 8'hC0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOAD,
        ST_PULSE,
        ST_VCMD,
        ST_VWAIT,
        ST_VREAD,
        ST_EXIT
    } st_e;

    typedef struct packed {
        logic       req;
        logic       we;
        logic [7:0] wdata;
    } bus_op_t;

    // Bus cycle presented in each state; the payload byte is used by the load write.
    function automatic bus_op_t op_for(st_e s, logic [7:0] payload);
        bus_op_t op;
        op = '{req: 1'b0, we: 1'b1, wdata: 8'h00};
        case (s)
            ST_SETUP: op = '{req: 1'b1, we: 1'b1, wdata: CMD_SETUP};
            ST_LOAD:  op = '{req: 1'b1, we: 1'b1, wdata: payload};
            ST_VCMD:  op = '{req: 1'b1, we: 1'b1, wdata: CMD_VERIFY};
            ST_VREAD: op = '{req: 1'b1, we: 1'b0, wdata: 8'h00};
            ST_EXIT:  op = '{req: 1'b1, we: 1'b1, wdata: CMD_READ};
            default:  op = '{req: 1'b0, we: 1'b1, wdata: 8'h00};
        endcase
        return op;
    endfunction

endpackage

// File: rtl/bps_wait_tmr.sv
module bps_wait_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/bps_pulse_ctr.sv
module bps_pulse_ctr #(
    parameter int MAX_PULSES = 25,
    parameter int W          = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_max
);
    localparam logic [W-1:0] LIMIT = W'(MAX_PULSES);

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc && count != LIMIT)
            count <= count + 1'b1;
    end

    assign at_max = (count == LIMIT);
endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
    import bps_pkg::*;
#(
    parameter int AW         = 17,
    parameter int PULSE_CYC  = 1250,
    parameter int VERIFY_CYC = 750,
    parameter int MAX_PULSES = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic [AW-1:0] req_span,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          hv_en,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic          bus_ack,
    input  logic [7:0]    bus_rdata
);
    localparam int WAIT_MAX = (PULSE_CYC > VERIFY_CYC) ? PULSE_CYC : VERIFY_CYC;
    localparam int TW       = $clog2(WAIT_MAX + 1);
    localparam int CW       = $clog2(MAX_PULSES + 1);
    localparam logic [TW-1:0] PULSE_T  = TW'(PULSE_CYC);
    localparam logic [TW-1:0] VERIFY_T = TW'(VERIFY_CYC);

    st_e           state;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] last_addr;
    logic [7:0]    want;
    logic          run_ok;
    bus_op_t       op;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          cnt_clr;
    logic          cnt_inc;
    logic [CW-1:0] pulse_cnt;
    logic          pulse_at_max;
    logic          read_hit;
    logic          read_match;

    assign op        = op_for(state, want);
    assign bus_req   = op.req;
    assign bus_we    = op.we;
    assign bus_wdata = op.wdata;
    assign bus_addr  = cur_addr;
    assign busy      = (state != ST_IDLE);

    assign read_hit   = (state == ST_VREAD) && bus_ack;
    assign read_match = (bus_rdata == want);

    assign tmr_load = bus_ack && (state == ST_LOAD || state == ST_VCMD);
    assign tmr_val  = (state == ST_LOAD) ? PULSE_T : VERIFY_T;
    assign cnt_inc  = bus_ack && (state == ST_LOAD);
    assign cnt_clr  = ((state == ST_IDLE) && start) || (read_hit && read_match);

    bps_wait_tmr #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    bps_pulse_ctr #(.MAX_PULSES(MAX_PULSES), .W(CW)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .count  (pulse_cnt),
        .at_max (pulse_at_max)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            last_addr <= '0;
            want      <= '0;
            run_ok    <= 1'b0;
            hv_en     <= 1'b0;
            done      <= 1'b0;
            pass      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    cur_addr  <= req_addr;
                    last_addr <= req_addr + req_span;
                    want      <= req_data;
                    run_ok    <= 1'b1;
                    pass      <= 1'b0;
                    hv_en     <= 1'b1;
                    state     <= ST_SETUP;
                end
                ST_SETUP: if (bus_ack) state <= ST_LOAD;
                ST_LOAD:  if (bus_ack) state <= ST_PULSE;
                ST_PULSE: if (tmr_done) state <= ST_VCMD;
                ST_VCMD:  if (bus_ack) state <= ST_VWAIT;
                ST_VWAIT: if (tmr_done) state <= ST_VREAD;
                ST_VREAD: if (bus_ack) begin
                    if (read_match) begin
                        if (cur_addr == last_addr) begin
                            state <= ST_EXIT;
                        end else begin
                            cur_addr <= cur_addr + 1'b1;
                            state    <= ST_SETUP;
                        end
                    end else if (pulse_at_max) begin
                        run_ok <= 1'b0;
                        state  <= ST_EXIT;
                    end else begin
                        state <= ST_SETUP;
                    end
                end
                ST_EXIT: if (bus_ack) begin
                    hv_en <= 1'b0;
                    done  <= 1'b1;
                    pass  <= run_ok;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bps_chk.sv
module bps_chk #(
    parameter int AW         = 17,
    parameter int CW         = 5,
    parameter int MAX_PULSES = 25
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          hv_en,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_ack,
    input logic [CW-1:0] pulse_cnt
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_req && !hv_en)); // R1

    AST_HV_ON_BUS: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> hv_en); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata))); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_HV_OFF: assert property (@(posedge clk) disable iff (rst)
        done |-> (!hv_en && !busy)); // R9

    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (rst)
        pulse_cnt <= CW'(MAX_PULSES)); // R6
endmodule

bind byte_prog_seq bps_chk #(.AW(AW), .CW(CW), .MAX_PULSES(MAX_PULSES)) chk_i (.*);

// File: tb/byte_prog_seq_tb_top.sv
module byte_prog_seq_tb_top;
    localparam int AW = 8;
    localparam int P  = 20;
    localparam int V  = 12;
    localparam int MP = 25;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic [AW-1:0] req_span = '0;
    logic          busy, done, pass, hv_en, bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_ack = 1'b0;
    logic [7:0]    bus_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    byte_prog_seq #(.AW(AW), .PULSE_CYC(P), .VERIFY_CYC(V), .MAX_PULSES(MP)) dut_i (.*);

    // Device model
    logic [7:0] mem   [256];
    int         need  [256];
    int         pcnt  [256];
    int         mode = 0;        // 0 read, 1 setup taken, 2 verify armed
    int         latched = 0;
    int         cyc = 0;
    int         t_prog = 0;
    int         t_vcmd = 0;
    int         gap_bad = 0;
    int         hv_bad = 0;
    int         exits = 0;
    int         addr_bad = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'hFF; need[i] = 1; pcnt[i] = 0;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (!hv_en) hv_bad++;
            if (bus_we) begin
                if (mode == 1) begin
                    latched = int'(bus_addr);
                    pcnt[latched]++;
                    if (pcnt[latched] >= need[latched]) mem[latched] = bus_wdata;
                    t_prog = cyc;
                    mode = 0;
                end else if (bus_wdata == 8'h40) begin
                    mode = 1;
                end else if (bus_wdata == 8'hC0) begin
                    if (cyc - t_prog <= P) gap_bad++;
                    t_vcmd = cyc;
                    mode = 2;
                end else if (bus_wdata == 8'h00) begin
                    exits++;
                    mode = 0;
                end
            end else begin
                if (mode == 2) begin
                    if (cyc - t_vcmd <= V) gap_bad++;
                    if (int'(bus_addr) != latched) addr_bad++;
                    bus_rdata = mem[latched];
                end else begin
                    bus_rdata = mem[int'(bus_addr)];
                end
            end
            bus_ack = 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] a, input logic [7:0] d, input logic [7:0] sp,
                       output bit res, output bit timed_out);
        timed_out = 1'b1;
        res = 1'b0;
        @(negedge clk);
        req_addr = a; req_data = d; req_span = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (done) begin
                timed_out = 1'b0;
                res = pass;
                break;
            end
        end
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0 && pass == 0, "R1 status after reset", int'({busy, done, pass}), 0);
        check(hv_en == 0 && bus_req == 0, "R1 hv/bus after reset", int'({hv_en, bus_req}), 0);
    endtask

    task automatic t_single();
        bit r, to;
        int e0 = exits;
        run(8'd5, 8'hA5, 8'd0, r, to);
        check(!to && r, "R9 single byte pass", int'(r), 1);
        check(mem[5] == 8'hA5, "R3 byte written at target", int'(mem[5]), 8'hA5);
        check(pcnt[5] == 1 && pcnt[6] == 0, "R11 span 0 one byte", pcnt[6], 0);
        check(exits == e0 + 1, "R9 read-mode write at end", exits - e0, 1);
        check(hv_en == 0 && busy == 0, "R9 hv dropped", int'(hv_en), 0);
        @(negedge clk);
        check(done == 0 && pass == 1, "R9 done one cycle, pass held", int'({done, pass}), 1);
    endtask

    task automatic t_retry();
        bit r, to;
        need[11] = 4;
        run(8'd10, 8'h3C, 8'd2, r, to);
        check(!to && r, "R6 range with retries passes", int'(r), 1);
        check(pcnt[11] == 4, "R6 retried byte pulses", pcnt[11], 4);
        check(pcnt[10] == 1 && pcnt[12] == 1, "R8 neighbours one pulse", pcnt[12], 1);
        check(mem[12] == 8'h3C && pcnt[13] == 0, "R11 span covers N+1 bytes", pcnt[13], 0);
    endtask

    task automatic t_edge();
        bit r, to;
        need[20] = MP;
        run(8'd20, 8'h00, 8'd1, r, to);
        check(!to && r, "R8 match on last allowed pulse passes", int'(r), 1);
        check(pcnt[20] == MP, "R8 pulses at limit byte", pcnt[20], MP);
        check(pcnt[21] == 1 && mem[21] == 8'h00, "R8 advance after limit byte", pcnt[21], 1);
    endtask

    task automatic t_fail();
        bit r, to;
        int e0 = exits;
        need[31] = MP + 1;
        run(8'd30, 8'h5A, 8'd2, r, to);
        check(!to && !r, "R7 run fails", int'(r), 0);
        check(pcnt[31] == MP, "R7 pulses before giving up", pcnt[31], MP);
        check(pcnt[32] == 0 && mem[32] == 8'hFF, "R7 later byte untouched", pcnt[32], 0);
        check(exits == e0 + 1 && hv_en == 0, "R7 read-mode write and hv off", exits - e0, 1);
    endtask

    task automatic t_busy();
        bit r, to;
        need[40] = 3;
        @(negedge clk);
        req_addr = 8'd40; req_data = 8'h77; req_span = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        req_addr = 8'd50; req_data = 8'h11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        to = 1'b1;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (done) begin to = 1'b0; r = pass; break; end
        end
        check(!to && r && pcnt[40] == 3, "R2 first run completes", pcnt[40], 3);
        repeat (40) @(negedge clk);
        check(pcnt[50] == 0 && mem[50] == 8'hFF && busy == 0, "R2 start while busy ignored", pcnt[50], 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_single();
        t_retry();
        t_edge();
        t_fail();
        t_busy();
        check(gap_bad == 0, "R4 R5 wait gaps", gap_bad, 0);
        check(hv_bad == 0, "R9 hv during bus cycles", hv_bad, 0);
        check(addr_bad == 0, "R5 verify read address", addr_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule